// File: doc/BRIEF.md
# Eight-Digit Decimal Word Adder

This block adds two 32-bit words that each carry eight 4-bit decimal digits and returns the decimal sum in the same coding as the operands. Two digit codings are handled, chosen per operation: natural binary-coded decimal, where a digit is its own value 0 to 9, and excess-3, where a digit is its value plus three (codes 3 to 12). The sum is formed in one binary pass whose nibble carries are made decimal-correct. In BCD mode one operand is first biased by six in every digit. In excess-3 mode the coding already carries a bias of six per digit pair, so no bias is added. A second, carry-free pass then repairs each digit on its own, steered by the carry that digit produced.

The per-digit carry vector is exported together with four condition flags: the decimal carry out of the word, a ten's-complement sign, a zero flag and a ten's-complement overflow. A caller presents operands with a one-cycle valid strobe. Result, carry vector and flags appear registered on the next clock edge with an output strobe, and they hold until the next operation. Operands that contain digit codes outside the chosen coding give unspecified results.

Top module: `decimal_word_adder`

## Requirements
- R1: With mode_i = 0 (BCD, digit i in bits [4i+3:4i], codes 0000 to 1001) and legal operands, sum_o is the decimal sum of the two eight-digit values modulo 10^8, in BCD.
- R2: With mode_i = 1 (excess-3, each digit coded as value + 3) and legal operands, sum_o is the decimal sum modulo 10^8, coded in excess-3.
- R3: Bit i of dcarry_o is 1 exactly when digit i's operand values plus the carry from digit i-1 reach 10 or more. Bit 0 belongs to the least significant digit, and there is no carry into digit 0.
- R4: flag_c_o equals the decimal carry out of the most significant digit.
- R5: flag_n_o is 1 when the value of the most significant result digit is 5 or more, meaning the result is negative in ten's complement.
- R6: flag_z_o is 1 when every result digit has value zero: 0x00000000 in BCD or 0x33333333 in excess-3.
- R7: flag_v_o is 1 when both operands have the same ten's-complement sign (top digit value below 5, or 5 and above) and the result's sign differs from it.
- R8: Result, carry vector and flags of an operation appear on the first rising edge after valid_i is sampled high, and valid_o is high for exactly the cycle that follows each sampled valid_i.
- R9: While valid_i is low, sum_o, dcarry_o and all four flags keep their values whatever the operands and mode do.
- R10: While rst_ni is low, sum_o, dcarry_o, the flags and valid_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and mode are valid this cycle |
| mode_i | input | 1 | Digit coding: 0 BCD, 1 excess-3 |
| a_i | input | 32 | First operand, eight digits |
| b_i | input | 32 | Second operand, eight digits |
| valid_o | output | 1 | Result strobe, one cycle per operation |
| sum_o | output | 32 | Corrected decimal sum |
| dcarry_o | output | 8 | Decimal carry out of each digit |
| flag_n_o | output | 1 | Ten's-complement negative |
| flag_z_o | output | 1 | Result value is zero |
| flag_v_o | output | 1 | Ten's-complement overflow |
| flag_c_o | output | 1 | Decimal carry out of the word |

## Verification
The assertions watch the timing of the output on every cycle: the one-cycle strobe after each accepted operation, the freeze of all outputs while no operation is presented, the zero result and empty carry vector for two zero operands in either coding, and the rule that a zero result never shows a negative sign. The digit-level arithmetic needs a decimal reference, so only the bench scenarios show it. These cover a pair that carries out of one digit only, a carry that ripples through seven digits, overflow into and out of the sign digit, alternate-digit carries, and the same sums repeated in excess-3.

// File: rtl/decadd_pkg.sv
package decadd_pkg;

    localparam int DIGIT_W = 4;

    typedef enum logic {
        CODE_BCD = 1'b0,
        CODE_XS3 = 1'b1
    } code_e;

    localparam logic [DIGIT_W-1:0] BCD_BIAS   = 4'd6;
    localparam logic [DIGIT_W-1:0] XS3_OFFSET = 4'd3;
    localparam logic [DIGIT_W-1:0] SIGN_LIMIT = 4'd5;

    // Numeric value of one digit under the selected coding.
    function automatic logic [DIGIT_W-1:0] digit_value(
        input logic [DIGIT_W-1:0] code,
        input code_e              coding
    );
        return (coding == CODE_XS3) ? code - XS3_OFFSET : code;
    endfunction

    // Code a digit of value zero takes under the selected coding.
    function automatic logic [DIGIT_W-1:0] zero_code(input code_e coding);
        return (coding == CODE_XS3) ? XS3_OFFSET : '0;
    endfunction

endpackage

// File: rtl/decadd_bias.sv
module decadd_bias
    import decadd_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  code_e                      coding_i,
    input  logic [DIGITS*DIGIT_W-1:0]  word_i,
    output logic [DIGITS*DIGIT_W-1:0]  word_o
);

    // In BCD every digit is raised by six so that a nibble overflows
    // exactly when the decimal digit sum reaches ten.
    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        logic [DIGIT_W-1:0] dig_in;
        assign dig_in = word_i[g*DIGIT_W +: DIGIT_W];
        assign word_o[g*DIGIT_W +: DIGIT_W] =
            (coding_i == CODE_BCD) ? dig_in + BCD_BIAS : dig_in;
    end

endmodule

// File: rtl/decadd_ripple.sv
module decadd_ripple
    import decadd_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  logic [DIGITS*DIGIT_W-1:0]  x_i,
    input  logic [DIGITS*DIGIT_W-1:0]  y_i,
    output logic [DIGITS*DIGIT_W-1:0]  raw_o,
    output logic [DIGITS-1:0]          carry_o
);

    localparam int PART_W = DIGIT_W + 1;

    logic [DIGITS:0] chain;
    assign chain[0] = 1'b0;

    // Binary add, one nibble per stage, every nibble carry kept.
    for (genvar g = 0; g < DIGITS; g++) begin : g_nib
        logic [PART_W-1:0] part;
        assign part = {1'b0, x_i[g*DIGIT_W +: DIGIT_W]}
                    + {1'b0, y_i[g*DIGIT_W +: DIGIT_W]}
                    + {{DIGIT_W{1'b0}}, chain[g]};
        assign raw_o[g*DIGIT_W +: DIGIT_W] = part[DIGIT_W-1:0];
        assign chain[g+1]                  = part[DIGIT_W];
    end

    assign carry_o = chain[DIGITS:1];

endmodule

// File: rtl/decadd_adjust.sv
module decadd_adjust
    import decadd_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  code_e                      coding_i,
    input  logic [DIGITS*DIGIT_W-1:0]  raw_i,
    input  logic [DIGITS-1:0]          carry_i,
    output logic [DIGITS*DIGIT_W-1:0]  fixed_o
);

    // Each digit is repaired alone; the nibble arithmetic wraps,
    // so nothing crosses a digit boundary in this pass.
    for (genvar g = 0; g < DIGITS; g++) begin : g_fix
        logic [DIGIT_W-1:0] raw_dig;
        logic [DIGIT_W-1:0] fix_dig;
        assign raw_dig = raw_i[g*DIGIT_W +: DIGIT_W];

        always_comb begin
            unique case (coding_i)
                CODE_BCD: fix_dig = carry_i[g] ? raw_dig : raw_dig - BCD_BIAS;
                CODE_XS3: fix_dig = carry_i[g] ? raw_dig + XS3_OFFSET
                                               : raw_dig - XS3_OFFSET;
                default:  fix_dig = raw_dig;
            endcase
        end

        assign fixed_o[g*DIGIT_W +: DIGIT_W] = fix_dig;
    end

endmodule

// File: rtl/decadd_flags.sv
module decadd_flags
    import decadd_pkg::*;
#(
    parameter int DIGITS = 8
) (
    input  code_e                      coding_i,
    input  logic [DIGITS*DIGIT_W-1:0]  a_i,
    input  logic [DIGITS*DIGIT_W-1:0]  b_i,
    input  logic [DIGITS*DIGIT_W-1:0]  res_i,
    input  logic [DIGITS-1:0]          carry_i,
    output logic                       n_o,
    output logic                       z_o,
    output logic                       v_o,
    output logic                       c_o
);

    localparam int TOP = (DIGITS - 1) * DIGIT_W;

    logic sign_a, sign_b, sign_r;
    logic [DIGITS-1:0] dig_zero;

    assign sign_a = digit_value(a_i[TOP +: DIGIT_W], coding_i) >= SIGN_LIMIT;
    assign sign_b = digit_value(b_i[TOP +: DIGIT_W], coding_i) >= SIGN_LIMIT;
    assign sign_r = digit_value(res_i[TOP +: DIGIT_W], coding_i) >= SIGN_LIMIT;

    for (genvar g = 0; g < DIGITS; g++) begin : g_zero
        assign dig_zero[g] = res_i[g*DIGIT_W +: DIGIT_W] == zero_code(coding_i);
    end

    assign n_o = sign_r;
    assign z_o = &dig_zero;
    assign v_o = (sign_a == sign_b) && (sign_r != sign_a);
    assign c_o = carry_i[DIGITS-1];

endmodule

// File: rtl/decimal_word_adder.sv
module decimal_word_adder
    import decadd_pkg::*;
#(
    parameter int DIGITS = 8,
    localparam int W     = DIGITS * DIGIT_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic              mode_i,
    input  logic [W-1:0]      a_i,
    input  logic [W-1:0]      b_i,
    output logic              valid_o,
    output logic [W-1:0]      sum_o,
    output logic [DIGITS-1:0] dcarry_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_v_o,
    output logic              flag_c_o
);

    typedef struct packed {
        logic [W-1:0]      sum;
        logic [DIGITS-1:0] dcarry;
        logic              n;
        logic              z;
        logic              v;
        logic              c;
        logic              vld;
    } out_t;

    code_e             coding;
    logic [W-1:0]      b_biased;
    logic [W-1:0]      raw_sum;
    logic [DIGITS-1:0] dig_carry;
    logic [W-1:0]      fixed_sum;
    logic              f_n, f_z, f_v, f_c;
    out_t              st_d, st_q;

    assign coding = code_e'(mode_i);

    decadd_bias #(.DIGITS(DIGITS)) u_bias (
        .coding_i (coding),
        .word_i   (b_i),
        .word_o   (b_biased)
    );

    decadd_ripple #(.DIGITS(DIGITS)) u_ripple (
        .x_i     (a_i),
        .y_i     (b_biased),
        .raw_o   (raw_sum),
        .carry_o (dig_carry)
    );

    decadd_adjust #(.DIGITS(DIGITS)) u_adjust (
        .coding_i (coding),
        .raw_i    (raw_sum),
        .carry_i  (dig_carry),
        .fixed_o  (fixed_sum)
    );

    decadd_flags #(.DIGITS(DIGITS)) u_flags (
        .coding_i (coding),
        .a_i      (a_i),
        .b_i      (b_i),
        .res_i    (fixed_sum),
        .carry_i  (dig_carry),
        .n_o      (f_n),
        .z_o      (f_z),
        .v_o      (f_v),
        .c_o      (f_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = valid_i;
        if (valid_i) begin
            st_d.sum    = fixed_sum;
            st_d.dcarry = dig_carry;
            st_d.n      = f_n;
            st_d.z      = f_z;
            st_d.v      = f_v;
            st_d.c      = f_c;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o  = st_q.vld;
    assign sum_o    = st_q.sum;
    assign dcarry_o = st_q.dcarry;
    assign flag_n_o = st_q.n;
    assign flag_z_o = st_q.z;
    assign flag_v_o = st_q.v;
    assign flag_c_o = st_q.c;

    AST_STROBE_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> valid_o); // R8

    AST_STROBE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !valid_o); // R8

    AST_OUTPUT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> ($stable(sum_o) && $stable(dcarry_o) && $stable(flag_n_o)
                      && $stable(flag_z_o) && $stable(flag_v_o) && $stable(flag_c_o))); // R9

    AST_ZERO_OPERANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && a_i == {DIGITS{zero_code(coding)}} && b_i == {DIGITS{zero_code(coding)}})
        |=> (flag_z_o && dcarry_o == '0 && !flag_c_o)); // R6

    AST_ZERO_NOT_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && flag_z_o) |-> !flag_n_o); // R5

endmodule

// File: tb/decimal_word_adder_tb_top.sv
`timescale 1ns/1ps
module decimal_word_adder_tb_top;

    typedef struct packed {
        logic        mode;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] sum;
        logic [7:0]  dc;
        logic [3:0]  nzvc;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 32'h00000045, 32'h00000046, 32'h00000091, 8'h01, 4'b0000},
        '{1'b0, 32'h99999999, 32'h00000001, 32'h00000000, 8'hFF, 4'b0101},
        '{1'b0, 32'h12345678, 32'h87654321, 32'h99999999, 8'h00, 4'b1000},
        '{1'b0, 32'h49999999, 32'h00000001, 32'h50000000, 8'h7F, 4'b1010},
        '{1'b0, 32'h50000000, 32'h50000000, 32'h00000000, 8'h80, 4'b0111},
        '{1'b0, 32'h00000000, 32'h00000000, 32'h00000000, 8'h00, 4'b0100},
        '{1'b1, 32'h33333378, 32'h33333379, 32'h333333C4, 8'h01, 4'b0000},
        '{1'b1, 32'hCCCCCCCC, 32'h33333334, 32'h33333333, 8'hFF, 4'b0101},
        '{1'b1, 32'h456789AB, 32'hBA987654, 32'hCCCCCCCC, 8'h00, 4'b1000},
        '{1'b1, 32'h33333333, 32'h33333333, 32'h33333333, 8'h00, 4'b0100},
        '{1'b0, 32'h09090909, 32'h01010101, 32'h10101010, 8'h55, 4'b0000},
        '{1'b1, 32'h3333338B, 32'h3333335A, 32'h333333B8, 8'h01, 4'b0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        valid_o;
    logic [31:0] sum_o;
    logic [7:0]  dcarry_o;
    logic        flag_n_o, flag_z_o, flag_v_o, flag_c_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    decimal_word_adder dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .valid_i  (valid_i),
        .mode_i   (mode_i),
        .a_i      (a_i),
        .b_i      (b_i),
        .valid_o  (valid_o),
        .sum_o    (sum_o),
        .dcarry_o (dcarry_o),
        .flag_n_o (flag_n_o),
        .flag_z_o (flag_z_o),
        .flag_v_o (flag_v_o),
        .flag_c_o (flag_c_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic m, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        valid_i = 1'b1;
        mode_i  = m;
        a_i     = a;
        b_i     = b;
    endtask

    task automatic check_vec(input vec_t v, input int idx);
        string tag;
        tag = $sformatf("vec%0d", idx);
        check(v.mode ? "R2" : "R1", {tag, " sum"}, sum_o, v.sum);
        check("R3", {tag, " digit carries"}, {24'd0, dcarry_o}, {24'd0, v.dc});
        check("R5", {tag, " N"}, {31'd0, flag_n_o}, {31'd0, v.nzvc[3]});
        check("R6", {tag, " Z"}, {31'd0, flag_z_o}, {31'd0, v.nzvc[2]});
        check("R7", {tag, " V"}, {31'd0, flag_v_o}, {31'd0, v.nzvc[1]});
        check("R4", {tag, " C"}, {31'd0, flag_c_o}, {31'd0, v.nzvc[0]});
        check("R8", {tag, " strobe"}, {31'd0, valid_o}, 32'd1);
    endtask

    task automatic report;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(200_000 * 5);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        // R10: outputs while reset is held
        repeat (3) @(negedge clk);
        check("R10", "reset sum", sum_o, 32'd0);
        check("R10", "reset carries", {24'd0, dcarry_o}, 32'd0);
        check("R10", "reset flags/strobe",
              {27'd0, valid_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o}, 32'd0);
        rst_n = 1'b1;

        // R1..R7 table walk, one operation at a time
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i].mode, VECS[i].a, VECS[i].b);
            @(negedge clk);
            valid_i = 1'b0;
            check_vec(VECS[i], i);
        end

        // R8: strobe lasts a single cycle, nothing before the edge
        drive(1'b0, 32'h00000045, 32'h00000046);
        check("R8", "no strobe before edge", {31'd0, valid_o}, 32'd0);
        @(negedge clk);
        valid_i = 1'b0;
        check("R8", "strobe after edge", {31'd0, valid_o}, 32'd1);
        check("R1", "latency sum", sum_o, 32'h00000091);
        @(negedge clk);
        check("R8", "strobe drops", {31'd0, valid_o}, 32'd0);

        // R9: operands and mode change while valid_i is low
        mode_i = 1'b1;
        a_i = 32'h99999999;
        b_i = 32'h99999999;
        repeat (3) @(negedge clk);
        check("R9", "held sum", sum_o, 32'h00000091);
        check("R9", "held carries", {24'd0, dcarry_o}, 32'h00000001);
        check("R9", "held flags", {28'd0, flag_n_o, flag_z_o, flag_v_o, flag_c_o}, 32'd0);

        // R8: back-to-back operations, mixed codings
        drive(1'b0, VECS[3].a, VECS[3].b);
        drive(1'b1, VECS[7].a, VECS[7].b);
        check_vec(VECS[3], 3);
        @(negedge clk);
        valid_i = 1'b0;
        check_vec(VECS[7], 7);

        // R10: reset in mid-run clears a non-zero result
        drive(1'b0, VECS[2].a, VECS[2].b);
        @(negedge clk);
        valid_i = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R10", "mid-run reset sum", sum_o, 32'd0);
        check("R10", "mid-run reset strobe", {31'd0, valid_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        report();
    end

endmodule